// File: doc/BRIEF.md
# Triple-Row Wordline Decoder

This block turns a row address into wordline selects for an array of `ROWS` rows. In ordinary access it raises the one wordline that the address names. When the majority mode bit is set, it raises three wordlines at once: the addressed row and the two rows after it. Three cells in one column can then be sensed together as a single majority vote. Wordlines only go high while the block is enabled and the wordline timing phase is high.

Internally the rows are split into three interleaved banks, one for each value of the row index modulo three. An address translator is pure logic with no register. It works out which banks take part and the local row inside each bank. Any three adjacent rows therefore land in three different banks, so each bank's own decoder still selects at most one row.

A majority group must not run past the last row. A request that would do so, or any address beyond the array, selects nothing and raises a range-error flag.

Top module: `tri_row_decoder`

## Requirements
- R1: With `maj_mode` = 0, `enable` = 1, `phase` = 1 and `row_addr` < `ROWS`, exactly one bit of `wordline` is high, at index `row_addr`.
- R2: With `maj_mode` = 1, `enable` = 1, `phase` = 1 and `row_addr` <= `ROWS`-3, exactly three bits of `wordline` are high, at indices `row_addr`, `row_addr`+1 and `row_addr`+2.
- R3: When `enable` = 0 or `phase` = 0, every bit of `wordline` is low, whatever the values of `row_addr` and `maj_mode`.
- R4: With `maj_mode` = 1 and `row_addr` equal to `ROWS`-2 or `ROWS`-1, no wordline is high and `range_err` = 1.
- R5: With `row_addr` >= `ROWS`, no wordline is high and `range_err` = 1 in either mode.
- R6: `range_err` depends only on `row_addr` and `maj_mode`. It is the same whatever the values of `enable` and `phase`, and it is 0 for every address that R1 or R2 covers.
- R7: The block has no clock or storage. `wordline` and `range_err` follow the inputs in the same cycle the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| row_addr | input | $clog2(ROWS) | Row address; the first row of the group in majority mode |
| maj_mode | input | 1 | 1 selects three adjacent rows, 0 selects one row |
| enable | input | 1 | Decoder enable |
| phase | input | 1 | Wordline timing phase; wordlines can go high only while it is 1 |
| wordline | output | ROWS | Wordline selects, bit i drives row i |
| range_err | output | 1 | The request is outside the array; all wordlines stay low |

## Verification
The bench drives every address, including the unused codes above the array, in both modes and for all four enable and phase combinations. For each input it compares the full wordline vector and the range flag with values it works out itself. The group starting points that cross a bank boundary are all covered. A translator that failed to add one to the local row of a bank below the starting residue would select a row three places too early in that bank. The last two starting rows in majority mode are the edge a careless design gets wrong: it would wrap the group to row 0, or raise only one or two wordlines instead of none. Gating is also checked with the range flag asserted. A decoder that let the flag depend on the phase would miscompare while the phase is low.

// File: rtl/tri_dec_pkg.sv
// Package: shared constants for the triple-row wordline decoder.
// Assumes the row count is a multiple of the bank count.
package tri_dec_pkg;
    // Number of interleaved banks; one per residue of the row index modulo 3.
    localparam int unsigned BANKS = 3;
endpackage

// File: rtl/tri_addr_xlat.sv
// Module: address translator.
// Splits the row address into a residue and a quotient by the bank count.
// For each bank it works out whether the bank takes part and which local row
// it drives. Pure logic, so it adds no cycle of delay.
// Assumes ROWS is a multiple of BANKS and that AW bits can hold ROWS-1.
module tri_addr_xlat
    import tri_dec_pkg::*;
#(
    parameter int unsigned ROWS = 24,
    parameter int unsigned AW   = $clog2(ROWS),
    parameter int unsigned LAW  = 3
) (
    input  logic [AW-1:0]  row_addr,
    input  logic           maj_mode,
    output logic [BANKS-1:0] bank_act,
    output logic [LAW-1:0] bank_idx [BANKS],
    output logic           range_err
);
    logic [AW-1:0] quot;
    logic [AW-1:0] resid;
    logic          past_end;
    logic          group_spill;

    // Split the address into a quotient and a residue by the bank count.
    always_comb begin
        quot  = row_addr / AW'(BANKS);
        resid = row_addr % AW'(BANKS);
    end

    // Flag requests that fall outside the array.
    always_comb begin
        past_end    = ({1'b0, row_addr} >= (AW+1)'(ROWS));
        group_spill = maj_mode && ({1'b0, row_addr} > (AW+1)'(ROWS - BANKS));
        range_err   = past_end || group_spill;
    end

    // Per bank: whether it takes part, and its local row. In a group, a bank
    // below the starting residue serves the row in the next block of three.
    for (genvar k = 0; k < BANKS; k++) begin : g_bank
        always_comb begin
            bank_act[k] = !range_err && (maj_mode || (resid == AW'(k)));
            if (maj_mode && (AW'(k) < resid))
                bank_idx[k] = LAW'(quot + AW'(1));
            else
                bank_idx[k] = LAW'(quot);
        end
    end
endmodule

// File: rtl/tri_bank_dec.sv
// Module: single-row decoder for one bank.
// Raises at most one local select, the one named by local_idx. It does so
// only when fire is high. Assumes local_idx < LROWS whenever fire is high.
module tri_bank_dec #(
    parameter int unsigned LROWS = 8,
    parameter int unsigned LAW   = 3
) (
    input  logic [LAW-1:0]   local_idx,
    input  logic             fire,
    output logic [LROWS-1:0] local_wl
);
    // One-hot decode of the local row, gated by fire.
    always_comb begin
        for (int j = 0; j < LROWS; j++)
            local_wl[j] = fire && (local_idx == LAW'(j));
    end
endmodule

// File: rtl/tri_row_decoder.sv
// Module: triple-row wordline decoder (top).
// Three interleaved bank decoders: row i belongs to bank i mod 3, as local
// row i / 3. The translator picks the banks and their local rows. Wordlines
// are gated by enable and phase. Pure logic, no clock.
// Assumes ROWS is a multiple of 3 and at least 3.
module tri_row_decoder
    import tri_dec_pkg::*;
#(
    parameter int unsigned ROWS = 24,
    parameter int unsigned AW   = $clog2(ROWS)
) (
    input  logic [AW-1:0]   row_addr,
    input  logic            maj_mode,
    input  logic            enable,
    input  logic            phase,
    output logic [ROWS-1:0] wordline,
    output logic            range_err
);
    localparam int unsigned LROWS = ROWS / BANKS;
    localparam int unsigned LAW   = (LROWS > 1) ? $clog2(LROWS) : 1;

    logic [BANKS-1:0] bank_act;
    logic [LAW-1:0]   bank_idx [BANKS];
    logic [LROWS-1:0] bank_wl  [BANKS];
    logic             strobe;

    // Wordline timing window: enable and phase both high.
    always_comb strobe = enable && phase;

    tri_addr_xlat #(.ROWS(ROWS), .AW(AW), .LAW(LAW)) u_xlat (
        .row_addr (row_addr),
        .maj_mode (maj_mode),
        .bank_act (bank_act),
        .bank_idx (bank_idx),
        .range_err(range_err)
    );

    for (genvar k = 0; k < BANKS; k++) begin : g_bank
        tri_bank_dec #(.LROWS(LROWS), .LAW(LAW)) u_dec (
            .local_idx(bank_idx[k]),
            .fire     (strobe && bank_act[k]),
            .local_wl (bank_wl[k])
        );
        // Interleave: local row j of bank k drives global row 3*j+k.
        for (genvar j = 0; j < LROWS; j++) begin : g_row
            assign wordline[BANKS*j + k] = bank_wl[k][j];
        end
    end

    // Checks on the assembled wordline vector against the port inputs.
    always_comb begin
        if (!strobe)
            p_gated_off_r3: assert (wordline == '0)
                else $error("wordline high outside the enable/phase window");
        if (range_err)
            p_oor_quiet_r4: assert (wordline == '0)
                else $error("wordline high with range error");
        if ({1'b0, row_addr} >= (AW+1)'(ROWS))
            p_past_end_r5: assert (range_err)
                else $error("address beyond array not flagged");
        if (strobe && !maj_mode && !range_err)
            p_single_row_r1: assert ($countones(wordline) == 1 &&
                                     (wordline & (ROWS'(1) << row_addr)) != '0)
                else $error("normal access did not select exactly the addressed row");
        if (strobe && maj_mode && !range_err)
            p_triple_row_r2: assert ($countones(wordline) == 3 &&
                                     (wordline & (ROWS'(7) << row_addr)) == (ROWS'(7) << row_addr))
                else $error("majority access did not select the three rows");
    end
endmodule

// File: tb/sim_tri_row_decoder.sv
// Scoreboard bench: the driver applies a vector at the falling edge and
// queues its expected result; the monitor pops and compares at the next
// rising edge.
module sim_tri_row_decoder;
    localparam int unsigned ROWS = 24;
    localparam int unsigned AW   = $clog2(ROWS);

    typedef struct {
        logic [ROWS-1:0] wl;
        logic            err;
        string           tag;
        int              addr;
        logic            maj;
        logic            en;
        logic            ph;
    } exp_t;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [AW-1:0]   row_addr = '0;
    logic            maj_mode = 1'b0;
    logic            enable   = 1'b0;
    logic            phase    = 1'b0;
    logic [ROWS-1:0] wordline;
    logic            range_err;

    int n_vec  = 0;
    int n_fail = 0;
    exp_t sb [$];

    tri_row_decoder #(.ROWS(ROWS)) u0 (
        .row_addr (row_addr),
        .maj_mode (maj_mode),
        .enable   (enable),
        .phase    (phase),
        .wordline (wordline),
        .range_err(range_err)
    );

    // Driver: compute the expected result from the requirements, apply the inputs.
    task automatic apply(input int a, input logic m, input logic e, input logic p);
        exp_t x;
        logic bad;
        @(negedge clk);
        bad = (a >= ROWS) || (m && a > ROWS - 3);
        x.err = bad;
        x.wl  = '0;
        for (int i = 0; i < ROWS; i++)
            if (e && p && !bad)
                x.wl[i] = m ? (i >= a && i <= a + 2) : (i == a);
        if (!(e && p))          x.tag = "R3";
        else if (a >= ROWS)     x.tag = "R5";
        else if (bad)           x.tag = "R4";
        else if (m)             x.tag = "R2";
        else                    x.tag = "R1";
        x.addr = a; x.maj = m; x.en = e; x.ph = p;
        row_addr = AW'(a);
        maj_mode = m;
        enable   = e;
        phase    = p;
        sb.push_back(x);
    endtask

    // Monitor: outputs are same-cycle logic (R7), so compare at the next rising edge.
    always @(posedge clk) begin
        if (sb.size() > 0) begin
            exp_t x;
            x = sb.pop_front();
            n_vec++;
            if (wordline !== x.wl) begin
                n_fail++;
                $display("FAIL %s/R7 wordline addr=%0d maj=%0b en=%0b ph=%0b actual=%h expected=%h",
                         x.tag, x.addr, x.maj, x.en, x.ph, wordline, x.wl);
            end
            if (range_err !== x.err) begin
                n_fail++;
                $display("FAIL R6 range_err addr=%0d maj=%0b en=%0b ph=%0b actual=%0b expected=%0b",
                         x.addr, x.maj, x.en, x.ph, range_err, x.err);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        // Idle state: all low with enable low (R3).
        apply(0, 1'b0, 1'b0, 1'b0);
        // Full sweep: every address code, both modes, every gating combination.
        for (int m = 0; m < 2; m++)
            for (int g = 0; g < 4; g++)
                for (int a = 0; a < (1 << AW); a++)
                    apply(a, m[0], g[1], g[0]);
        // Edges of majority range back to back (R4, R2).
        apply(ROWS - 3, 1'b1, 1'b1, 1'b1);
        apply(ROWS - 2, 1'b1, 1'b1, 1'b1);
        apply(ROWS - 1, 1'b1, 1'b1, 1'b1);
        apply(ROWS - 1, 1'b0, 1'b1, 1'b1);
        // Mode flip on the same address (R1, R2).
        apply(5, 1'b1, 1'b1, 1'b1);
        apply(5, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule